// File: doc/BRIEF.md
# Column-Bus Matrix Load and Drain Unit

This block holds the load and drain logic of a square mesh of processing elements (PEs), together with each PE's accumulator and two local operand stores. An external memory port broadcasts one row vector per cycle across the mesh's column buses, one element per bus. Each row carries a tag that names the matrix it belongs to (the result matrix, the left operand or the right operand) and the row's position inside its group of `NR` rows. Every PE filters that stream on its own. There is no address decoding and no arbitration. A PE keeps an element when the row position equals its own row in the mesh. Kept elements go to the accumulator, to the left-operand store or to the right-operand store, and each store has its own write pointer that auto-increments. The left operand is sent in square blocks, so that each block of `NR` rows fills one new store word in every PE.

In the optional replicated mode for the right operand, every PE in a column keeps every right-operand row that arrives on its bus. A whole column of that matrix is then local to each PE. A pulse on the phase-start input returns all write pointers to their base. After a drain request, the same column buses carry results back: one mesh row drives all columns in each cycle, starting at row 0. A small sequencer controls this with two states. `ST_IDLE` accepts load rows. `IDLE->DRAIN` is taken on `drain_i`. `ST_DRAIN` walks the row position 0..NR-1 and takes `DRAIN->IDLE` after the last row. A combinational read port exposes one PE's accumulator or one word of its stores to the computation side.

Top module: `colbus_xfer`

## Requirements
- R1: After reset every accumulator and store word reads 0, every write pointer is 0, `col_vld_o` is 0 and `col_bus_o` is 0.
- R2: A valid row with tag 2'b01 (result matrix), accepted in `ST_IDLE` with row position r, loads element j (bits j*DW +: DW) into the accumulator of PE(r, j) at the next edge. All other accumulators keep their values.
- R3: A valid row with tag 2'b10 (left operand) and row position r writes element j into the left-operand store of PE(r, j) at that PE's pointer. The pointer then increments and wraps modulo KC/NR.
- R4: A valid row with tag 2'b11 (right operand) while `repl_b_i`=0 writes element j into the right-operand store of PE(r, j) at its pointer. The pointer then increments and wraps modulo KC.
- R5: While `repl_b_i`=1, a valid right-operand row writes element j into the right-operand store of every PE in column j, and each of those pointers increments.
- R6: A row has no effect on any accumulator, store or pointer if its valid bit is low, if its tag is 2'b00, or if it arrives while in `ST_DRAIN`.
- R7: `phase_start_i` sets every write pointer to 0 at the next edge. A row presented in the same cycle is dropped.
- R8: `drain_i` in `ST_IDLE` makes the following NR cycles show `col_vld_o`=1 and `col_row_o`=0,1,..,NR-1. Bus j then carries the accumulator of PE(`col_row_o`, j). Outside those cycles `col_vld_o`, `col_row_o` and `col_bus_o` are 0.
- R9: In every drain cycle exactly one PE drives each column bus. No PE drives outside a drain.
- R10: `drain_i` during `ST_DRAIN` neither restarts nor extends the drain.
- R11: `rd_data_o` returns the accumulator of PE(`rd_row_i`,`rd_col_i`) when `rd_sel_i`=0, left-operand word `rd_addr_i` mod KC/NR when it is 1, right-operand word `rd_addr_i` when it is 2, and 0 when it is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld_i | input | 1 | Qualifies the row on the buses |
| bus_tag_i | input | 2 | Matrix tag: 01 result, 10 left, 11 right, 00 none |
| bus_row_i | input | log2(NR) | Row position within the current group of NR rows |
| bus_data_i | input | NR*DW | One element per column bus |
| repl_b_i | input | 1 | Replicate right-operand rows down each column |
| phase_start_i | input | 1 | Reset all write pointers to base |
| drain_i | input | 1 | Start draining accumulators |
| col_bus_o | output | NR*DW | Column buses during drain |
| col_vld_o | output | 1 | Drain row valid |
| col_row_o | output | log2(NR) | Mesh row currently driving |
| rd_row_i | input | log2(NR) | Read port PE row |
| rd_col_i | input | log2(NR) | Read port PE column |
| rd_sel_i | input | 2 | 0 accumulator, 1 left store, 2 right store, 3 none |
| rd_addr_i | input | log2(KC) | Store word address |
| rd_data_o | output | DW | Read data |

## Verification
Assertions check on every cycle that each column has a single driver during a drain and none outside it (R9). They also check that the drain row position advances one step per cycle from 0, that accumulators capture their own row of a result-matrix stream, that a rejected row leaves accumulator and pointers untouched, and that phase start clears the pointers. Only the bench scenarios can show where the data ends up. These cover the placement of left blocks and right rows across pointer wrap, the replicated mode filling all PEs of a column, rows dropped during a drain or on a phase start, and the order of the drained values. The bench shows these by comparing every store word through the read port against a behavioural model.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
    typedef enum logic [1:0] {
        TAG_NONE = 2'b00,
        TAG_C    = 2'b01,
        TAG_A    = 2'b10,
        TAG_B    = 2'b11
    } tag_e;

    typedef enum logic [1:0] {
        RD_ACC  = 2'd0,
        RD_A    = 2'd1,
        RD_B    = 2'd2,
        RD_NONE = 2'd3
    } rdsel_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } st_e;
endpackage

// File: rtl/cbx_seq.sv
module cbx_seq #(
    parameter int NR = 4,
    localparam int RW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drain_i,
    output logic          idle_o,
    output logic          drain_o,
    output logic [RW-1:0] p_o
);
    import cbx_pkg::*;

    st_e           st, st_nx;
    logic [RW-1:0] p, p_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            p  <= '0;
        end else begin
            st <= st_nx;
            p  <= p_nx;
        end
    end

    always_comb begin
        st_nx = st;
        p_nx  = p;
        unique case (st)
            ST_IDLE: begin
                if (drain_i) begin
                    st_nx = ST_DRAIN;
                    p_nx  = '0;
                end
            end
            ST_DRAIN: begin
                if (p == RW'(NR - 1)) begin
                    st_nx = ST_IDLE;
                    p_nx  = '0;
                end else begin
                    p_nx = p + 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        idle_o  = (st == ST_IDLE);
        drain_o = (st == ST_DRAIN);
        p_o     = p;
    end

    // R8: drain row position walks one step per cycle
    p_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DRAIN && p != RW'(NR - 1)) |=> (st == ST_DRAIN && p == $past(p) + 1'b1));
    // R8 R10: drain starts at row 0 only from idle
    p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && drain_i) |=> (st == ST_DRAIN && p == '0));
endmodule

// File: rtl/cbx_pe.sv
module cbx_pe #(
    parameter int NR  = 4,
    parameter int DW  = 16,
    parameter int KC  = 8,
    parameter int ROW = 0,
    localparam int RW   = $clog2(NR),
    localparam int DA   = KC / NR,
    localparam int AW_A = $clog2(DA),
    localparam int AW_B = $clog2(KC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idle_i,
    input  logic            draining_i,
    input  logic [RW-1:0]   p_i,
    input  logic            vld_i,
    input  logic [1:0]      tag_i,
    input  logic [RW-1:0]   row_i,
    input  logic [DW-1:0]   data_i,
    input  logic            repl_i,
    input  logic            start_i,
    input  logic [AW_A-1:0] rda_i,
    input  logic [AW_B-1:0] rdb_i,
    output logic [DW-1:0]   acc_o,
    output logic [DW-1:0]   a_o,
    output logic [DW-1:0]   b_o,
    output logic            drv_o
);
    import cbx_pkg::*;

    logic [DW-1:0]   acc;
    logic [DW-1:0]   amem [DA];
    logic [DW-1:0]   bmem [KC];
    logic [AW_A-1:0] pa;
    logic [AW_B-1:0] pb;

    logic accept, mine, wr_c, wr_a, wr_b;
    tag_e tag;

    always_comb begin
        tag    = tag_e'(tag_i);
        accept = idle_i && vld_i && !start_i;
        mine   = (row_i == RW'(ROW));
        wr_c   = accept && tag == TAG_C && mine;
        wr_a   = accept && tag == TAG_A && mine;
        wr_b   = accept && tag == TAG_B && (mine || repl_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            pa  <= '0;
            pb  <= '0;
            for (int k = 0; k < DA; k++) amem[k] <= '0;
            for (int k = 0; k < KC; k++) bmem[k] <= '0;
        end else begin
            if (start_i) begin
                pa <= '0;
                pb <= '0;
            end
            if (wr_c) acc <= data_i;
            if (wr_a) begin
                amem[pa] <= data_i;
                pa       <= pa + 1'b1;
            end
            if (wr_b) begin
                bmem[pb] <= data_i;
                pb       <= pb + 1'b1;
            end
        end
    end

    always_comb begin
        acc_o = acc;
        a_o   = amem[rda_i];
        b_o   = bmem[rdb_i];
        drv_o = draining_i && (p_i == RW'(ROW));
    end

    // R2: own-row result element captured into the accumulator
    p_c_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && vld_i && !start_i && tag_i == 2'b01 && row_i == RW'(ROW))
        |=> (acc == $past(data_i)));
    // R6: rejected rows leave accumulator and pointers alone
    p_no_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && (!vld_i || tag_i == 2'b00 || !idle_i))
        |=> ($stable(acc) && $stable(pa) && $stable(pb)));
    // R7: phase start returns pointers to base
    p_ptr_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (pa == '0 && pb == '0));
endmodule

// File: rtl/colbus_xfer.sv
module colbus_xfer #(
    parameter int NR = 4,
    parameter int DW = 16,
    parameter int KC = 8,
    localparam int RW   = $clog2(NR),
    localparam int AW_A = $clog2(KC / NR),
    localparam int AW_B = $clog2(KC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_vld_i,
    input  logic [1:0]       bus_tag_i,
    input  logic [RW-1:0]    bus_row_i,
    input  logic [NR*DW-1:0] bus_data_i,
    input  logic             repl_b_i,
    input  logic             phase_start_i,
    input  logic             drain_i,
    output logic [NR*DW-1:0] col_bus_o,
    output logic             col_vld_o,
    output logic [RW-1:0]    col_row_o,
    input  logic [RW-1:0]    rd_row_i,
    input  logic [RW-1:0]    rd_col_i,
    input  logic [1:0]       rd_sel_i,
    input  logic [AW_B-1:0]  rd_addr_i,
    output logic [DW-1:0]    rd_data_o
);
    import cbx_pkg::*;

    logic          idle, draining;
    logic [RW-1:0] p;
    logic [DW-1:0] acc_w [NR][NR];
    logic [DW-1:0] a_w   [NR][NR];
    logic [DW-1:0] b_w   [NR][NR];
    logic          drv_w [NR][NR];
    logic [DW-1:0] col_d [NR];

    cbx_seq #(.NR(NR)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .drain_i (drain_i),
        .idle_o  (idle),
        .drain_o (draining),
        .p_o     (p)
    );

    for (genvar gi = 0; gi < NR; gi++) begin : g_row
        for (genvar gj = 0; gj < NR; gj++) begin : g_col
            cbx_pe #(.NR(NR), .DW(DW), .KC(KC), .ROW(gi)) u_pe (
                .clk        (clk),
                .rst_n      (rst_n),
                .idle_i     (idle),
                .draining_i (draining),
                .p_i        (p),
                .vld_i      (bus_vld_i),
                .tag_i      (bus_tag_i),
                .row_i      (bus_row_i),
                .data_i     (bus_data_i[gj*DW +: DW]),
                .repl_i     (repl_b_i),
                .start_i    (phase_start_i),
                .rda_i      (rd_addr_i[AW_A-1:0]),
                .rdb_i      (rd_addr_i),
                .acc_o      (acc_w[gi][gj]),
                .a_o        (a_w[gi][gj]),
                .b_o        (b_w[gi][gj]),
                .drv_o      (drv_w[gi][gj])
            );
        end
    end

    always_comb begin
        for (int j = 0; j < NR; j++) begin
            col_d[j] = '0;
            for (int i = 0; i < NR; i++) begin
                if (drv_w[i][j]) col_d[j] = col_d[j] | acc_w[i][j];
            end
        end
    end

    for (genvar gj = 0; gj < NR; gj++) begin : g_bus
        logic [NR-1:0] drv_col;
        always_comb begin
            for (int i = 0; i < NR; i++) drv_col[i] = drv_w[i][gj];
        end
        assign col_bus_o[gj*DW +: DW] = col_d[gj];

        // R9: single driver per column while draining
        p_one_driver_r9: assert property (@(posedge clk) disable iff (!rst_n)
            col_vld_o |-> ($countones(drv_col) == 1));
        // R9: no driver outside a drain
        p_no_driver_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !col_vld_o |-> (drv_col == '0));
    end

    assign col_vld_o = draining;
    assign col_row_o = p;

    always_comb begin
        unique case (rdsel_e'(rd_sel_i))
            RD_ACC:  rd_data_o = acc_w[rd_row_i][rd_col_i];
            RD_A:    rd_data_o = a_w[rd_row_i][rd_col_i];
            RD_B:    rd_data_o = b_w[rd_row_i][rd_col_i];
            RD_NONE: rd_data_o = '0;
        endcase
    end
endmodule

// File: tb/colbus_xfer_tb.sv
`timescale 1ns/1ps
module colbus_xfer_tb;
    localparam int NR = 4;
    localparam int DW = 16;
    localparam int KC = 8;
    localparam int DA = KC / NR;

    logic             clk = 0;
    logic             rst_n = 0;
    logic             bus_vld_i = 0;
    logic [1:0]       bus_tag_i = 0;
    logic [1:0]       bus_row_i = 0;
    logic [NR*DW-1:0] bus_data_i = 0;
    logic             repl_b_i = 0;
    logic             phase_start_i = 0;
    logic             drain_i = 0;
    logic [NR*DW-1:0] col_bus_o;
    logic             col_vld_o;
    logic [1:0]       col_row_o;
    logic [1:0]       rd_row_i = 0;
    logic [1:0]       rd_col_i = 0;
    logic [1:0]       rd_sel_i = 0;
    logic [2:0]       rd_addr_i = 0;
    logic [DW-1:0]    rd_data_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    colbus_xfer #(.NR(NR), .DW(DW), .KC(KC)) u_dut (.*);

    // behavioural reference
    int macc [NR][NR];
    int mA   [NR][NR][DA];
    int mB   [NR][NR][KC];
    int pa   [NR][NR];
    int pb   [NR][NR];
    bit mdr;
    int mp;
    bit was_idle;

    always @(posedge clk) begin
        if (!rst_n) begin
            mdr = 0; mp = 0;
            for (int i = 0; i < NR; i++) for (int j = 0; j < NR; j++) begin
                macc[i][j] = 0; pa[i][j] = 0; pb[i][j] = 0;
                for (int k = 0; k < DA; k++) mA[i][j][k] = 0;
                for (int k = 0; k < KC; k++) mB[i][j][k] = 0;
            end
        end else begin
            was_idle = !mdr;
            if (mdr) begin
                if (mp == NR - 1) begin mdr = 0; mp = 0; end
                else mp++;
            end else if (drain_i) begin
                mdr = 1; mp = 0;
            end
            if (phase_start_i) begin
                for (int i = 0; i < NR; i++) for (int j = 0; j < NR; j++) begin
                    pa[i][j] = 0; pb[i][j] = 0;
                end
            end else if (was_idle && bus_vld_i && bus_tag_i != 2'b00) begin
                for (int i = 0; i < NR; i++) for (int j = 0; j < NR; j++) begin
                    int d;
                    bit mine;
                    d = int'(bus_data_i[j*DW +: DW]);
                    mine = (int'(bus_row_i) == i);
                    if (bus_tag_i == 2'b01 && mine) macc[i][j] = d;
                    if (bus_tag_i == 2'b10 && mine) begin
                        mA[i][j][pa[i][j]] = d; pa[i][j] = (pa[i][j] + 1) % DA;
                    end
                    if (bus_tag_i == 2'b11 && (mine || repl_b_i)) begin
                        mB[i][j][pb[i][j]] = d; pb[i][j] = (pb[i][j] + 1) % KC;
                    end
                end
            end
        end
    end

    // per-cycle comparison of drain outputs (R1 R8 R9)
    always @(negedge clk) begin
        bit ok;
        logic [NR*DW-1:0] exp_bus;
        exp_bus = '0;
        if (mdr) for (int j = 0; j < NR; j++) exp_bus[j*DW +: DW] = DW'(macc[mp][j]);
        ok = (col_vld_o == mdr) && (int'(col_row_o) == (mdr ? mp : 0)) && (col_bus_o == exp_bus);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R8 R9 drain outputs: vld=%0d row=%0d bus=%h expected vld=%0d row=%0d bus=%h",
                     col_vld_o, col_row_o, col_bus_o, mdr, mdr ? mp : 0, exp_bus);
        end
    end

    task automatic cyc(input bit v, input logic [1:0] t, input int r, input int seed,
                       input bit st, input bit dr, input bit rp);
        @(negedge clk);
        bus_vld_i = v; bus_tag_i = t; bus_row_i = 2'(r);
        for (int j = 0; j < NR; j++) bus_data_i[j*DW +: DW] = DW'(seed * 16 + j + 1);
        phase_start_i = st; drain_i = dr; repl_b_i = rp;
    endtask

    task automatic idle();
        cyc(0, 2'b00, 0, 0, 0, 0, repl_b_i);
    endtask

    task automatic rd_chk(input string req, input int i, input int j, input int s,
                          input int a, input int exp);
        rd_row_i = 2'(i); rd_col_i = 2'(j); rd_sel_i = 2'(s); rd_addr_i = 3'(a);
        #0.2;
        checks++;
        if (int'(rd_data_o) != exp) begin
            errors++;
            $display("FAIL %s PE(%0d,%0d) sel=%0d addr=%0d: got %h expected %h",
                     req, i, j, s, a, rd_data_o, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NR; i++) for (int j = 0; j < NR; j++) begin
            rd_chk({req, " R11"}, i, j, 0, 0, macc[i][j]);
            for (int k = 0; k < DA; k++) rd_chk({req, " R11"}, i, j, 1, k, mA[i][j][k]);
            for (int k = 0; k < KC; k++) rd_chk({req, " R11"}, i, j, 2, k, mB[i][j][k]);
            rd_chk("R11", i, j, 3, 0, 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog expired: got running expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        idle();
        check_all("R1");

        // R2: result rows, one per mesh row
        for (int r = 0; r < NR; r++) cyc(1, 2'b01, r, 16'hC0 + r, 0, 0, 0);
        // R6: invalid row and tag-none row
        cyc(0, 2'b01, 1, 16'hE1, 0, 0, 0);
        cyc(1, 2'b00, 2, 16'hE2, 0, 0, 0);
        idle();
        check_all("R2 R6");
        cyc(1, 2'b01, 1, 16'hC9, 0, 0, 0);
        idle();
        check_all("R2");

        // R8 R10 R6: drain, with a second request and a load row inside it
        cyc(0, 2'b00, 0, 0, 0, 1, 0);
        cyc(0, 2'b00, 0, 0, 0, 0, 0);
        cyc(1, 2'b01, 0, 16'hEE, 0, 1, 0);
        idle();
        repeat (4) idle();
        check_all("R6 R10");

        // R3 R7: left operand blocks
        cyc(0, 2'b00, 0, 0, 1, 0, 0);
        for (int k = 0; k < KC + NR; k++) cyc(1, 2'b10, k % NR, 16'hA0 + k, 0, 0, 0);
        idle();
        check_all("R3 R7");

        // R4: right operand, distributed
        cyc(0, 2'b00, 0, 0, 1, 0, 0);
        for (int k = 0; k < KC; k++) cyc(1, 2'b11, k % NR, 16'hB0 + k, 0, 0, 0);
        idle();
        check_all("R4");

        // R5: right operand, replicated
        cyc(0, 2'b00, 0, 0, 1, 0, 1);
        for (int k = 0; k < KC; k++) cyc(1, 2'b11, k % NR, 16'h50 + k, 0, 0, 1);
        cyc(0, 2'b00, 0, 0, 0, 0, 0);
        check_all("R5");

        // R7: row on the phase-start cycle is dropped, next row lands at base
        cyc(1, 2'b10, 2, 16'h71, 1, 0, 0);
        cyc(1, 2'b10, 2, 16'h72, 0, 0, 0);
        idle();
        check_all("R7");

        // R8: final drain
        cyc(0, 2'b00, 0, 0, 0, 1, 0);
        repeat (NR + 2) idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule